// File: doc/BRIEF.md
# Folded Energy Template Correlator

This block scores how well the recent power profile of a received stream matches a known preamble power profile. Each accepted input is the instantaneous power of one received sample, in unsigned fixed point. The block correlates a 128-sample window of these values against a template of squared preamble amplitudes. The template is two identical halves of 64 entries each. Peaks in the output mark the points where the received energy lines up with the preamble, so a timing search placed after this block can look for those peaks.

Because the two template halves are equal, the block first adds each input to the input received 64 accepted samples earlier. This folded value then drives a single set of 64 taps. The taps are arranged as a transposed chain: each stage adds its own weighted term to the partial sum that arrives from the stage before it, through a single-sample register. Every coefficient is a 2-bit code with a step of one half. As a result, each tap is built from a select and a one-bit shift, and no multiplier is used. The output keeps a fixed integer range of 6 bits and a fractional width that is set by a parameter.

Top module: `pwr_tmpl_corr`

## Requirements
- R1: While reset is asserted and after its release, before any sample has been accepted, `metric_valid_o` is 0 and `metric_o` is 0.
- R2: The value that feeds the taps for accepted sample n is x(n) + x(n-64), where x counts accepted samples only and has the value 0 before the first sample. As a result, a single nonzero input adds to the metric twice, 64 accepted samples apart.
- R3: `metric_valid_o` stays 0 until 128 samples have been accepted since reset.
- R4: From the 128th accepted sample onwards, `metric_valid_o` is 1 in the cycle after each accepted sample. It is 0 in every other cycle.
- R5: After accepted sample n, `metric_o` equals the sum over j = 0..63 of t(c[63-j], F(n-j)), where F is the folded value from R2. The function t is defined as t(c,F) = (c bit 1 ? F : 0) + (c bit 0 ? floor(F/2) : 0). All values are in input LSB units, and the result updates one clock after the sample.
- R6: A cycle in which `pwr_valid_i` is 0 does not shift the history and leaves `metric_o` unchanged.
- R7: When the sum in R5 is larger than 2^(6+FRAC_W)-1, `metric_o` holds that all-ones value instead.
- R8: The code for tap index k sits in bits [2k+1:2k] of `COEF_CODES`. Code values 0, 1, 2 and 3 mean weights 0, 0.5, 1.0 and 1.5. Index 63 weights the newest folded value, and index 0 weights the folded value from 63 samples earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_valid_i | input | 1 | An input sample is present this cycle |
| pwr_i | input | FRAC_W+1 | Sample power, unsigned, 1 integer bit and FRAC_W fraction bits |
| metric_valid_o | output | 1 | The window is full and the metric was updated by the last accepted sample |
| metric_o | output | OUT_INT_W+FRAC_W | Energy matching metric, unsigned, saturating |

## Verification
The case that is hardest to reach is a fold that pairs a sample with its partner from exactly 64 accepted samples earlier while idle cycles are mixed into the stream. Here, a delay line that counts clock cycles gives a different result from one that counts accepted samples. To reach it, the stimulus first flushes the history with zeros and then sends a single impulse. After that it sends zeros, with random idle gaps in between. The expected metric traces the reversed code list twice, 64 accepted samples apart. Saturation is reached with a long burst of full-scale samples. The gate on the valid output is checked sample by sample up to the 128th sample and across that boundary.

// File: rtl/ecorr_pkg.sv
package ecorr_pkg;
   localparam int CODE_W   = 2;
   localparam int MAX_TAPS = 256;

   // Default template: a spread of all four weight codes.
   function automatic logic [CODE_W*MAX_TAPS-1:0] spread_codes();
      logic [CODE_W*MAX_TAPS-1:0] v;
      v = '0;
      for (int k = 0; k < MAX_TAPS; k++) begin
         v[CODE_W*k +: CODE_W] = CODE_W'((k ^ (k >> 2)) & 3);
      end
      return v;
   endfunction
endpackage

// File: rtl/ecorr_fold.sv
module ecorr_fold #(
   parameter int IN_W = 7,
   parameter int HALF = 64,
   localparam int FOLD_W = IN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [IN_W-1:0]   x_i,
   output logic [FOLD_W-1:0] fold_o
);
   logic [IN_W-1:0] line_q [HALF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < HALF; i++) line_q[i] <= '0;
      end else if (en) begin
         line_q[0] <= x_i;
         for (int i = 1; i < HALF; i++) line_q[i] <= line_q[i-1];
      end
   end

   assign fold_o = FOLD_W'(x_i) + FOLD_W'(line_q[HALF-1]);
endmodule

// File: rtl/ecorr_tap.sv
module ecorr_tap #(
   parameter int          FOLD_W = 8,
   parameter int          ACC_W  = 15,
   parameter logic [1:0]  CODE   = 2'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [FOLD_W-1:0] fold_i,
   input  logic [ACC_W-1:0]  acc_i,
   output logic [ACC_W-1:0]  acc_o
);
   logic [ACC_W-1:0] whole, half, term;

   generate
      if (CODE[1]) begin : g_whole
         assign whole = ACC_W'(fold_i);
      end else begin : g_no_whole
         assign whole = '0;
      end
      if (CODE[0]) begin : g_half
         assign half = ACC_W'(fold_i >> 1);
      end else begin : g_no_half
         assign half = '0;
      end
   endgenerate

   assign term = whole + half;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc_o <= '0;
      else if (en) acc_o <= acc_i + term;
   end
endmodule

// File: rtl/ecorr_fill.sv
module ecorr_fill #(
   parameter int TARGET = 128,
   localparam int CNT_W = $clog2(TARGET)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic ready_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             full_q;
   logic             last;

   assign last = (cnt_q == CNT_W'(TARGET - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         full_q  <= 1'b0;
         ready_o <= 1'b0;
      end else begin
         ready_o <= en && (full_q || last);
         if (en && !last) cnt_q <= cnt_q + 1'b1;
         if (en && last)  full_q <= 1'b1;
      end
   end
endmodule

// File: rtl/pwr_tmpl_corr.sv
module pwr_tmpl_corr #(
   parameter int FRAC_W    = 6,
   parameter int TAPS      = 64,
   parameter int OUT_INT_W = 6,
   parameter logic [ecorr_pkg::CODE_W*ecorr_pkg::MAX_TAPS-1:0] COEF_CODES = ecorr_pkg::spread_codes(),
   localparam int IN_W   = FRAC_W + 1,
   localparam int OUT_W  = OUT_INT_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_valid_i,
   input  logic [IN_W-1:0]  pwr_i,
   output logic             metric_valid_o,
   output logic [OUT_W-1:0] metric_o
);
   localparam int FOLD_W = IN_W + 1;
   localparam int ACC_W  = FOLD_W + 1 + $clog2(TAPS);
   localparam int CW     = ecorr_pkg::CODE_W;

   generate
      if (FRAC_W < 1 || FRAC_W > 15) begin : g_bad_frac
         $error("FRAC_W must lie in 1..15");
      end
      if (TAPS < 2 || TAPS > ecorr_pkg::MAX_TAPS) begin : g_bad_taps
         $error("TAPS out of range");
      end
      if (OUT_INT_W < 1) begin : g_bad_out
         $error("OUT_INT_W must be positive");
      end
   endgenerate

   logic [FOLD_W-1:0] fold;
   logic [ACC_W-1:0]  acc     [TAPS];
   logic [ACC_W-1:0]  chain_in[TAPS];

   ecorr_fold #(.IN_W(IN_W), .HALF(TAPS)) fold_i (
      .clk(clk), .rst_n(rst_n), .en(pwr_valid_i), .x_i(pwr_i), .fold_o(fold)
   );

   generate
      for (genvar g = 0; g < TAPS; g++) begin : g_tap
         if (g == 0) begin : g_head
            assign chain_in[g] = '0;
         end else begin : g_link
            assign chain_in[g] = acc[g-1];
         end
         ecorr_tap #(.FOLD_W(FOLD_W), .ACC_W(ACC_W), .CODE(COEF_CODES[CW*g +: CW])) tap_i (
            .clk(clk), .rst_n(rst_n), .en(pwr_valid_i),
            .fold_i(fold), .acc_i(chain_in[g]), .acc_o(acc[g])
         );
      end
   endgenerate

   ecorr_fill #(.TARGET(2*TAPS)) fill_i (
      .clk(clk), .rst_n(rst_n), .en(pwr_valid_i), .ready_o(metric_valid_o)
   );

   generate
      if (ACC_W > OUT_W) begin : g_sat
         assign metric_o = (|acc[TAPS-1][ACC_W-1:OUT_W]) ? {OUT_W{1'b1}}
                                                         : acc[TAPS-1][OUT_W-1:0];
      end else begin : g_wide
         assign metric_o = OUT_W'(acc[TAPS-1]);
      end
   endgenerate
endmodule

// File: rtl/pwr_tmpl_corr_chk.sv
module pwr_tmpl_corr_chk #(
   parameter int TAPS  = 64,
   parameter int OUT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             out_valid,
   input logic [OUT_W-1:0] metric
);
   localparam int SEEN_W = $clog2(2*TAPS) + 1;
   logic [SEEN_W-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else if (in_valid && seen_q < SEEN_W'(2*TAPS)) seen_q <= seen_q + 1'b1;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!out_valid && metric == '0)
            else $error("R1 outputs not cleared in reset");
      end
   end

   assert_fill_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> seen_q >= SEEN_W'(2*TAPS));

   assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   assert_valid_each_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && seen_q >= SEEN_W'(2*TAPS - 1)) |=> out_valid);

   assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(metric));
endmodule

bind pwr_tmpl_corr pwr_tmpl_corr_chk #(.TAPS(TAPS), .OUT_W(OUT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(pwr_valid_i),
   .out_valid(metric_valid_o), .metric(metric_o)
);

// File: tb/pwr_tmpl_corr_tb_top.sv
module pwr_tmpl_corr_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int FRAC_W = 6;
   localparam int TAPS   = 64;
   localparam int IN_W   = FRAC_W + 1;
   localparam int OUT_W  = 6 + FRAC_W;
   localparam int MAXV   = (1 << OUT_W) - 1;

   function automatic logic [511:0] tb_codes();
      logic [511:0] v;
      v = '0;
      for (int k = 0; k < 256; k++) v[2*k +: 2] = 2'((k*3 + 1) % 4);
      return v;
   endfunction

   function automatic int code_of(int k);
      return (k*3 + 1) % 4;
   endfunction

   logic             clk = 0;
   logic             rst_n = 0;
   logic             pwr_valid_i = 0;
   logic [IN_W-1:0]  pwr_i = '0;
   logic             metric_valid_o;
   logic [OUT_W-1:0] metric_o;

   int checks = 0;
   int failures = 0;
   int hist[2*TAPS];
   int accepted = 0;
   int exp_metric = 0;
   bit done = 0;

   pwr_tmpl_corr #(.FRAC_W(FRAC_W), .TAPS(TAPS), .OUT_INT_W(6), .COEF_CODES(tb_codes())) dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_valid_i(pwr_valid_i), .pwr_i(pwr_i),
      .metric_valid_o(metric_valid_o), .metric_o(metric_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int model_metric();
      int s = 0;
      for (int j = 0; j < TAPS; j++) begin
         int f = hist[j] + hist[j+TAPS];
         int c = code_of(TAPS-1-j);
         s += ((c & 2) != 0 ? f : 0) + ((c & 1) != 0 ? f / 2 : 0);
      end
      return (s > MAXV) ? MAXV : s;
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Drives one cycle, then checks outputs 1 time unit after the edge.
   task automatic step(input bit v, input int x, input string mtag);
      pwr_valid_i = v;
      pwr_i = IN_W'(x);
      @(posedge clk);
      #1;
      if (v) begin
         for (int i = 2*TAPS-1; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = x;
         accepted++;
         exp_metric = model_metric();
         check(accepted <= 2*TAPS ? "R3" : "R4", "valid", int'(metric_valid_o),
               accepted >= 2*TAPS ? 1 : 0);
         check(mtag, "metric", int'(metric_o), exp_metric);
      end else begin
         check("R4", "valid idle", int'(metric_valid_o), 0);
         check("R6", "metric idle", int'(metric_o), exp_metric);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 2*TAPS; i++) hist[i] = 0;
      repeat (4) @(posedge clk);
      #1;
      check("R1", "valid in reset", int'(metric_valid_o), 0);
      check("R1", "metric in reset", int'(metric_o), 0);
      rst_n = 1;
      @(posedge clk);
      #1;
      check("R1", "valid after reset", int'(metric_valid_o), 0);
      check("R1", "metric after reset", int'(metric_o), 0);

      // Fill window with random small powers and idle gaps (R3 boundary).
      while (accepted < 2*TAPS + 20) begin
         if ($urandom_range(0, 3) == 0) step(0, $urandom_range(0, 127), "R6");
         else step(1, $urandom_range(0, 15), "R5");
      end

      // Flush with zeros, then a single impulse (R2 fold, R8 ordering).
      for (int i = 0; i < 2*TAPS; i++) step(1, 0, "R5");
      step(1, 100, "R8");
      for (int i = 0; i < 2*TAPS + 10; i++) begin
         if ($urandom_range(0, 2) == 0) step(0, 77, "R6");
         step(1, 0, "R2");
      end

      // Random patterns over a wider range.
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(0, 4) == 0) step(0, $urandom_range(0, 127), "R6");
         else step(1, $urandom_range(0, 40), "R5");
      end

      // Full-scale burst drives saturation (R7), then decays back.
      for (int i = 0; i < 2*TAPS; i++) step(1, 127, "R7");
      check("R7", "saturated value", int'(metric_o), MAXV);
      for (int i = 0; i < 2*TAPS; i++) step(1, $urandom_range(0, 5), "R7");

      // Reset mid-stream clears everything again (R1).
      rst_n = 0;
      #1;
      check("R1", "valid on reset", int'(metric_valid_o), 0);
      check("R1", "metric on reset", int'(metric_o), 0);
      @(posedge clk);
      #1;
      rst_n = 1;
      for (int i = 0; i < 2*TAPS; i++) hist[i] = 0;
      accepted = 0;
      exp_metric = 0;
      for (int i = 0; i < 2*TAPS + 3; i++) step(1, $urandom_range(0, 12), "R5");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule